// File: doc/BRIEF.md
# Striped DDR Word Link (Six Lanes, 10:1)

This block moves one wide parallel word per system cycle from one board to another over several serial data lanes and one forwarded clock lane. The transmit half takes a 60-bit word once per system cycle and splits it into six 10-bit slices. It shifts each slice out on its own lane at double data rate. The receive half samples every lane on both edges of the bit clock, rebuilds each slice and puts the 60-bit word back together. The word leaves the receiver exactly four system cycles after the transmitter took it.

The block is a synchronous behavioural model, so it has no vendor serializer cells and no PLL. It runs from one bit clock whose frequency is five times the system rate. A system cycle is five bit-clock periods, which is ten half-periods, one for each bit of a lane. A phase counter marks the system cycle and reports its last bit-clock period on `word_sync`. The user presents a word while `word_sync` is high, and the word is taken at the rising edge that ends that period. The lanes are looped back inside the block to the receiver, and they are also driven out to the ports.

With the default sizes, an 80 MHz system rate gives 800 Mb/s per lane. This stays below the 1050 Mb/s that the lane drivers allow.

Top module: `ddrl_link`

## Requirements
- R1: While `rst_n` is low (it is sampled on the bit clock), every data lane is held at 0, `rx_valid` is 0 and `rx_word` is 0.
- R2: After reset, `word_sync` is high for exactly one bit-clock period in every five. `tx_word` is captured at the rising edge that ends a period in which `word_sync` is high.
- R3: Lane k (`lane_data[k]`) carries captured bits [10k+9:10k], for k from 0 to 5.
- R4: A captured word goes to the serializers at the next system-cycle boundary. Bit 0 of each lane then appears first, at the rising edge that follows that boundary. Bits follow in ascending order, one on each bit-clock edge.
- R5: Even-numbered bits of a lane start at rising edges of the bit clock, and odd-numbered bits start at falling edges. Each bit lasts half a bit-clock period.
- R6: `lane_clk` carries the bit clock itself: it is high while the even bits are driven and low while the odd bits are driven.
- R7: A word captured at one system-cycle boundary appears on `rx_word` just after the fourth boundary that follows. After reset release, exactly five `word_sync` periods with `rx_valid` low come before the first valid word.
- R8: `rx_valid` rises only at a system-cycle boundary. Once high, it stays high on every cycle until the next reset.
- R9: Every word with `rx_valid` high equals the `tx_word` captured four system cycles earlier, bit for bit, for any data pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock at five times the system rate; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word | input | 60 | Parallel word to send; sampled at the end of a `word_sync` period |
| word_sync | output | 1 | High during the last bit-clock period of each system cycle |
| lane_data | output | 6 | Serial data lanes, one bit per bit-clock edge |
| lane_clk | output | 1 | Forwarded clock lane |
| rx_word | output | 60 | Reassembled word at the receiver |
| rx_valid | output | 1 | High while `rx_word` holds a word that went through the link |

## Verification
The bench builds the block with its defaults: six lanes of ten bits, so five bit-clock periods per system cycle and a 60-bit word. With these values every bit position of every lane can be watched on the pins. This covers lane mapping and bit order through a walking one across all sixty bits, and the split between rising and falling edges on each pair. A word stream with no gaps checks the exact four-cycle latency and the length of the run-in of `rx_valid`. A second reset in the middle of traffic checks that the lanes go quiet and that the run-in starts again.

// File: rtl/ddrl_pkg.sv
// Shared constants of the striped DDR word link.
// Assumes: latency is counted in system cycles, a system cycle being
// LANE_BITS/2 bit-clock periods.
package ddrl_pkg;
    // Boundaries between word capture and the receiver output register.
    localparam int unsigned LINK_LATENCY = 4;
    // Phase value at which the receiver parks a fully assembled word.
    localparam int unsigned RX_PARK_PHASE = 1;
endpackage

// File: rtl/ddrl_phase.sv
// System-cycle phase counter.
// Counts bit-clock periods modulo PHASES and flags the last period of each
// system cycle. Assumes PHASES >= 3 and PH_W wide enough to hold PHASES-1.
module ddrl_phase #(
    parameter int unsigned PHASES = 5,
    parameter int unsigned PH_W   = 3
) (
    input  logic            clk_bit,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            sys_edge
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    // Advance the phase, wrapping at the end of each system cycle.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // The rising edge that ends a LAST period is a system-cycle boundary.
    assign sys_edge = (phase == LAST);

    // R2: a boundary is always followed by phase zero.
    p_wrap_after_edge_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
        sys_edge |=> (phase == '0));
endmodule

// File: rtl/ddrl_tx_lane.sv
// Transmit side of one lane.
// Takes a LANE_BITS slice at a system boundary, turns it into bit pairs, one
// pair per bit-clock period, and drives the even bit from the rising edge and
// the odd bit from the falling edge. The output flop reacts to both clock
// edges; it is a behavioural model of a DDR output cell.
// Assumes LANE_BITS is even and at least 6.
module ddrl_tx_lane #(
    parameter int unsigned LANE_BITS = 10
) (
    input  logic                 clk_bit,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [LANE_BITS-1:0] slice,
    output logic                 lane_q
);
    localparam int unsigned PEND_W = LANE_BITS - 2;

    logic [PEND_W-1:0] pend_q;
    logic              ev_q;
    logic              od_q;
    logic              od_hold_q;

    // Take the first pair from a fresh slice, otherwise step to the next pair.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            pend_q <= '0;
            ev_q   <= 1'b0;
            od_q   <= 1'b0;
        end else if (load) begin
            ev_q   <= slice[0];
            od_q   <= slice[1];
            pend_q <= slice[LANE_BITS-1:2];
        end else begin
            ev_q   <= pend_q[0];
            od_q   <= pend_q[1];
            pend_q <= pend_q >> 2;
        end
    end

    // Delay the odd bit so that it follows its even partner by half a period.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            od_hold_q <= 1'b0;
        else
            od_hold_q <= od_q;
    end

    // DDR output: even bit on the rising edge, odd bit on the falling edge.
    always_ff @(posedge clk_bit or negedge clk_bit) begin
        if (!rst_n)
            lane_q <= 1'b0;
        else if (clk_bit)
            lane_q <= ev_q;
        else
            lane_q <= od_hold_q;
    end

    // R1: a lane sampled in reset is low at the following edge.
    p_lane_quiet_r1: assert property (@(posedge clk_bit)
        !rst_n |=> (lane_q == 1'b0));
endmodule

// File: rtl/ddrl_rx_lane.sv
// Receive side of one lane.
// Captures the bit driven in the high half of the clock at the falling edge,
// and the bit driven in the low half at the next rising edge. Each pair is
// then shifted into a LANE_BITS register, lowest bits first.
// Assumes the lane is driven from the same bit clock (forwarded clock).
module ddrl_rx_lane #(
    parameter int unsigned LANE_BITS = 10
) (
    input  logic                 clk_bit,
    input  logic                 rst_n,
    input  logic                 lane_in,
    output logic [LANE_BITS-1:0] asm_q
);
    logic ev_cap_q;

    // Falling-edge capture of the even bit.
    always_ff @(negedge clk_bit) begin
        if (!rst_n)
            ev_cap_q <= 1'b0;
        else
            ev_cap_q <= lane_in;
    end

    // Rising-edge capture of the odd bit, pushing the pair in from the top.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            asm_q <= '0;
        else
            asm_q <= {lane_in, ev_cap_q, asm_q[LANE_BITS-1:2]};
    end
endmodule

// File: rtl/ddrl_link.sv
// Striped DDR word link, top level.
// Captures a word at every system boundary and hands it to the serializers
// at the next boundary. The word is striped over LANES DDR lanes with the bit
// clock forwarded, assembled again per lane, parked, and passed through
// realignment stages to give a fixed LINK_LATENCY system cycles.
// Assumes clk_bit is the bit clock and LANE_BITS is even and at least 6.
module ddrl_link #(
    parameter int unsigned LANES     = 6,
    parameter int unsigned LANE_BITS = 10
) (
    input  logic                         clk_bit,
    input  logic                         rst_n,
    input  logic [LANES*LANE_BITS-1:0]   tx_word,
    output logic                         word_sync,
    output logic [LANES-1:0]             lane_data,
    output logic                         lane_clk,
    output logic [LANES*LANE_BITS-1:0]   rx_word,
    output logic                         rx_valid
);
    import ddrl_pkg::*;

    localparam int unsigned WORD_W     = LANES * LANE_BITS;
    localparam int unsigned PHASES     = LANE_BITS / 2;
    localparam int unsigned PH_W       = $clog2(PHASES);
    localparam int unsigned OUT_STAGES = LINK_LATENCY - 2;

    logic [PH_W-1:0]   phase;
    logic              sys_edge;
    logic [WORD_W-1:0] cap_q;
    logic [WORD_W-1:0] rx_asm;
    logic [WORD_W-1:0] park_q;
    logic [WORD_W-1:0] stage_q [OUT_STAGES];
    logic [LINK_LATENCY:0] vld_q;
    logic [LANES-1:0]  lane_q;

    ddrl_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .phase    (phase),
        .sys_edge (sys_edge)
    );

    // Input capture once per system cycle.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            cap_q <= '0;
        else if (sys_edge)
            cap_q <= tx_word;
    end

    // One serializer and one deserializer for each lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddrl_tx_lane #(.LANE_BITS(LANE_BITS)) u_tx (
            .clk_bit (clk_bit),
            .rst_n   (rst_n),
            .load    (sys_edge),
            .slice   (cap_q[g*LANE_BITS +: LANE_BITS]),
            .lane_q  (lane_q[g])
        );
        ddrl_rx_lane #(.LANE_BITS(LANE_BITS)) u_rx (
            .clk_bit (clk_bit),
            .rst_n   (rst_n),
            .lane_in (lane_q[g]),
            .asm_q   (rx_asm[g*LANE_BITS +: LANE_BITS])
        );
    end

    assign lane_data = lane_q;
    assign lane_clk  = clk_bit;

    // Park the word once its last pair has been shifted in.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            park_q <= '0;
        else if (phase == PH_W'(RX_PARK_PHASE))
            park_q <= rx_asm;
    end

    // Realignment stages that move the parked word onto system boundaries.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            for (int i = 0; i < OUT_STAGES; i++) stage_q[i] <= '0;
        end else if (sys_edge) begin
            stage_q[0] <= park_q;
            for (int i = 1; i < OUT_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Valid pipeline: one mark per boundary since reset.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)
            vld_q <= '0;
        else if (sys_edge)
            vld_q <= {vld_q[LINK_LATENCY-1:0], 1'b1};
    end

    assign rx_word   = stage_q[OUT_STAGES-1];
    assign rx_valid  = vld_q[LINK_LATENCY];
    assign word_sync = sys_edge;

    // R7: the output word changes only at a system boundary.
    p_out_steady_r7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !$past(word_sync) |-> $stable(rx_word));
    // R8: the strobe rises only at a boundary.
    p_valid_at_edge_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(word_sync));
    // R8: once up, the strobe stays up until reset.
    p_valid_sticky_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
        rx_valid |=> rx_valid);
endmodule

// File: tb/ddrl_link_test.sv
`timescale 1ns/1ps
module ddrl_link_test;
    localparam int CLK_PERIOD = 12;
    localparam int LANES      = 6;
    localparam int LANE_BITS  = 10;
    localparam int WORD_W     = LANES * LANE_BITS;
    localparam int PHASES     = LANE_BITS / 2;
    localparam int LATENCY    = 4;
    localparam int QTR        = CLK_PERIOD / 4;

    logic              clk_bit = 1'b0;
    logic              rst_n   = 1'b0;
    logic [WORD_W-1:0] tx_word = '0;
    logic              word_sync;
    logic [LANES-1:0]  lane_data;
    logic              lane_clk;
    logic [WORD_W-1:0] rx_word;
    logic              rx_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [WORD_W-1:0] exp_q [$];

    ddrl_link #(.LANES(LANES), .LANE_BITS(LANE_BITS)) uut (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .tx_word   (tx_word),
        .word_sync (word_sync),
        .lane_data (lane_data),
        .lane_clk  (lane_clk),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

    task automatic check(input bit ok, input string req,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one word per system cycle and record it.
    task automatic drive(input logic [WORD_W-1:0] w);
        do @(negedge clk_bit); while (!word_sync);
        #1;
        tx_word = w;
        exp_q.push_back(w);
    endtask

    function automatic logic [WORD_W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[WORD_W-1:0];
    endfunction

    // Scoreboard monitor: cadence, run-in length and data.
    initial begin
        int pre = 0;
        int gap = 0;
        bit seen = 1'b0;
        bit first_ws = 1'b1;
        logic [WORD_W-1:0] e;
        forever begin
            @(negedge clk_bit);
            if (!rst_n) begin
                pre = 0; gap = 0; seen = 1'b0; first_ws = 1'b1;
                continue;
            end
            gap++;
            if (word_sync) begin
                if (!first_ws) check(gap == PHASES, "R2 sync period", gap, PHASES);
                first_ws = 1'b0;
                gap = 0;
                if (rx_valid) begin
                    if (!seen) begin
                        check(pre == LATENCY + 1, "R7 run-in length", pre, LATENCY + 1);
                        seen = 1'b1;
                    end
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 word without stimulus", rx_word, '0);
                    end else begin
                        e = exp_q.pop_front();
                        check(rx_word == e, "R9 R7 received word", rx_word, e);
                    end
                end else begin
                    if (seen) check(1'b0, "R8 valid dropped", 0, 1);
                    pre++;
                end
            end
        end
    end

    // Lane monitor: decode the serial lanes independently of the receiver.
    initial begin
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] got;
        bit live;
        bit clk_ok;
        forever begin
            @(negedge clk_bit);
            if (!(rst_n && word_sync)) continue;
            w = tx_word;
            got = '0;
            live = 1'b1;
            clk_ok = 1'b1;
            @(posedge clk_bit);
            for (int p = 0; p < PHASES; p++) begin
                @(posedge clk_bit);
                #(QTR);
                if (!rst_n) live = 1'b0;
                if (lane_clk !== 1'b1) clk_ok = 1'b0;
                for (int l = 0; l < LANES; l++) got[l*LANE_BITS + 2*p] = lane_data[l];
                @(negedge clk_bit);
                #(QTR);
                if (!rst_n) live = 1'b0;
                if (lane_clk !== 1'b0) clk_ok = 1'b0;
                for (int l = 0; l < LANES; l++) got[l*LANE_BITS + 2*p + 1] = lane_data[l];
            end
            if (live && rst_n) begin
                check(got == w, "R3 R4 R5 lane stream", got, w);
                check(clk_ok, "R6 forwarded clock", clk_ok, 1);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        logic [WORD_W-1:0] w;
        repeat (3) @(negedge clk_bit);
        #(QTR);
        check(lane_data == '0, "R1 lanes in reset", lane_data, '0);
        check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
        check(rx_word == '0, "R1 word in reset", rx_word, '0);
        @(negedge clk_bit);
        rst_n = 1'b1;

        drive('0);
        drive({WORD_W{1'b1}});
        drive({(WORD_W/2){2'b01}});
        drive({(WORD_W/2){2'b10}});
        for (int b = 0; b < WORD_W; b++) drive(WORD_W'(1) << b);
        for (int l = 0; l < LANES; l++) w[l*LANE_BITS +: LANE_BITS] = LANE_BITS'(10'h2C5 ^ (l * 37));
        drive(w);
        for (int i = 0; i < 20; i++) drive(rnd_word());
        for (int i = 0; i < 6; i++) drive('0);

        // Reset in the middle of traffic.
        @(negedge clk_bit);
        rst_n = 1'b0;
        tx_word = '0;
        exp_q.delete();
        repeat (3) begin
            @(negedge clk_bit);
            #(QTR);
            check(lane_data == '0, "R1 lanes after second reset", lane_data, '0);
            check(rx_valid == 1'b0, "R1 valid after second reset", rx_valid, 0);
        end
        @(negedge clk_bit);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) drive(rnd_word());
        for (int i = 0; i < 6; i++) drive('0);
        repeat (3) @(negedge clk_bit);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule